// File: doc/BRIEF.md
# Single-Channel DMA Transfer Engine

This block is one DMA channel: a small register file and the state machine behind it. Software uses a simple register bus to load a memory start address, a memory end address, a device address and a control word. The channel then copies data units of 1, 2 or 4 bytes between the memory side and the device side, in either direction, through a single-beat bus master port. Each unit is one read followed by one write. The memory address climbs by the unit size after every unit, and the transfer ends when it becomes equal to the programmed end address. No byte counter exists.

A transfer is paced in one of two ways. In software mode, one go bit runs the whole block back to back. In hardware mode, every unit waits for a device request line picked by a 7-bit request ID. The channel reports busy and done and sets sticky interrupt status bits, which software clears by writing ones. Abort stops the channel at the next unit boundary. A state register shows the control state so software can watch progress.

The state machine has five states. IDLE (code 0) leaves for ARB on start. ARB (code 1) goes back to IDLE on abort or kill, to FIN when the memory address equals the end address, or to RD when the unit may proceed. RD (code 2) issues the read and goes to WR on acknowledge, or to IDLE on an error response or kill. WR (code 3) issues the write and goes to ARB on acknowledge with the addresses stepped, or to IDLE on error or kill. FIN (code 4) reports done and returns to IDLE.

Top module: `dmac_chan_engine`

## Requirements
- R1: After reset every register reads zero, `irq` is low and `m_req` is low. Writing a 1 to bit 1 of the main control register (offset 0x00) clears every channel register (0x40 to 0x5C) to zero. That bit always reads 0, and bit 0 (global enable) takes the written bit 0.
- R2: The channel registers sit at fixed offsets: activate 0x40 (bit 0), current memory address 0x44, memory end address 0x48, device address 0x4C, control 0x50, interrupt status 0x54 (bits 3:0), interrupt enable 0x58 (bits 3:0) and state 0x5C (read-only). The control fields read back where they were written: bit 8 memory-to-device, bits 15:9 request ID, bit 16 memory increment, bit 17 device increment, bit 18 arbitration lock, bit 19 software pacing, bits 22:20 unit code.
- R3: When control bit 19 is set, setting control bit 24 (go) starts a transfer, but only while activate bit 0 and global enable bit 0 are both 1. A go that is pending starts as soon as both become 1.
- R4: With bit 8 set, each unit is read at the memory address and written at the device address. With bit 8 clear, the order is reversed. Each access drives `m_be` as the unit mask shifted left by the access address bits 1:0, and the data moves from the source byte lane to the destination byte lane.
- R5: Unit code 2 selects 2-byte units and code 4 selects 4-byte units; any other code selects 1 byte. After each unit the memory address rises by the unit size only if bit 16 is set, and the device address rises only if bit 17 is set.
- R6: A transfer ends when the memory address equals the end address. The channel then clears busy (control bit 5) and sets control bit 2 (done) and status bit 2. If the start address already equals the end address, the transfer finishes with no bus access.
- R7: When bit 19 is clear, setting control bit 0 (run) starts a transfer in which each unit waits for `dev_req[id]`, where id is control bits 15:9. An ID of `REQ_N` or more never matches. Control bit 1 reads the selected request line.
- R8: Writing control bit 25 (abort) while busy stops the channel before the next unit begins. Status bit 3 is set, done is not set, busy clears, and the memory address stays on a whole-unit boundary.
- R9: An error response on either access sets status bit 0 and ends the transfer. The failed unit does not step the addresses.
- R10: Writing ones to status bits clears them and writing zeros leaves them. `irq` is high whenever some status bit and its matching enable bit are both 1.
- R11: State register bits 15:8 read 0 (IDLE), 1 (ARB), 2 (RD), 3 (WR) or 4 (FIN). Bit 0 reads 1 while a hardware-paced channel is waiting for its request line.
- R12: Clearing activate (or global enable) during a transfer returns the channel to IDLE on the following cycle, with busy clear.
- R13: While busy, writes to the three address registers are ignored. A control write while busy changes only the abort bit, and at the end of a transfer run, go and abort clear while the other control fields keep their values.
- R14: `m_req` is high only while the channel is busy. A request that has not been acknowledged keeps its address and direction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_addr | input | 7 | Register byte address |
| reg_we | input | 1 | Register write strobe |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational from reg_addr) |
| m_req | output | 1 | Bus master request |
| m_we | output | 1 | Bus master write (1) or read (0) |
| m_addr | output | AW | Bus master byte address |
| m_be | output | 4 | Bus master byte enables |
| m_wdata | output | 32 | Bus master write data |
| m_rdata | input | 32 | Bus master read data |
| m_ack | input | 1 | Bus acknowledge |
| m_err | input | 1 | Bus error response, valid with m_ack |
| dev_req | input | REQ_N | Device request lines |
| irq | output | 1 | Interrupt output |

## Verification
The assertions assume that the bus slave never raises `m_err` without `m_ack`. They also assume that software programs start and end addresses aligned to the unit size, with the end address reachable from the start address in whole units. The bench's memory model acknowledges every request in the same cycle, and it answers with an error only at one chosen address. Every programmed transfer uses aligned bases and lengths that are whole multiples of the unit, and the memory and device windows never overlap, so the expected copy can be computed byte by byte in the bench.

// File: rtl/dmac_pkg.sv
package dmac_pkg;

    typedef enum logic [7:0] {
        XS_IDLE = 8'd0,
        XS_ARB  = 8'd1,
        XS_RD   = 8'd2,
        XS_WR   = 8'd3,
        XS_FIN  = 8'd4
    } xfer_state_e;

    localparam logic [6:0] OFS_MAIN = 7'h00;
    localparam logic [6:0] OFS_ACT  = 7'h40;
    localparam logic [6:0] OFS_MEM  = 7'h44;
    localparam logic [6:0] OFS_END  = 7'h48;
    localparam logic [6:0] OFS_DEV  = 7'h4C;
    localparam logic [6:0] OFS_CTL  = 7'h50;
    localparam logic [6:0] OFS_STS  = 7'h54;
    localparam logic [6:0] OFS_IEN  = 7'h58;
    localparam logic [6:0] OFS_FSM  = 7'h5C;

    localparam int CB_RUN   = 0;
    localparam int CB_REQ   = 1;
    localparam int CB_DONE  = 2;
    localparam int CB_BUSY  = 5;
    localparam int CB_M2D   = 8;
    localparam int CB_ID_LO = 9;
    localparam int CB_INCM  = 16;
    localparam int CB_INCD  = 17;
    localparam int CB_LOCK  = 18;
    localparam int CB_SWP   = 19;
    localparam int CB_UN_LO = 20;
    localparam int CB_GO    = 24;
    localparam int CB_ABT   = 25;

    localparam int ST_BERR = 0;
    localparam int ST_OVFL = 1;
    localparam int ST_DONE = 2;
    localparam int ST_TERM = 3;

endpackage

// File: rtl/dmac_req_sel.sv
module dmac_req_sel #(
    parameter int REQ_N = 16,
    parameter int ID_W  = 7
) (
    input  logic [REQ_N-1:0] dev_req,
    input  logic [ID_W-1:0]  sel_id,
    output logic             sel_hit
);
    logic [REQ_N-1:0] match;

    generate
        for (genvar g = 0; g < REQ_N; g++) begin : g_line
            assign match[g] = dev_req[g] && (sel_id == ID_W'(g));
        end
    endgenerate

    assign sel_hit = |match;
endmodule

// File: rtl/dmac_unit_dec.sv
module dmac_unit_dec (
    input  logic [2:0] unit_code,
    input  logic [1:0] lane,
    output logic [2:0] unit_bytes,
    output logic [3:0] lane_be
);
    logic [3:0] mask;

    always_comb begin
        unique case (unit_code)
            3'd2: begin
                unit_bytes = 3'd2;
                mask       = 4'b0011;
            end
            3'd4: begin
                unit_bytes = 3'd4;
                mask       = 4'b1111;
            end
            default: begin
                unit_bytes = 3'd1;
                mask       = 4'b0001;
            end
        endcase
        lane_be = mask << lane;
    end
endmodule

// File: rtl/dmac_xfer_fsm.sv
module dmac_xfer_fsm
    import dmac_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        clr,
    input  logic        start,
    input  logic        run_ok,
    input  logic        sw_mode,
    input  logic        req_hit,
    input  logic        abort_req,
    input  logic        at_end,
    input  logic        bus_ack,
    input  logic        bus_err,
    output xfer_state_e state,
    output logic        busy,
    output logic        bus_req,
    output logic        bus_wr,
    output logic        arb_wait,
    output logic        ev_latch,
    output logic        ev_step,
    output logic        ev_done,
    output logic        ev_abort,
    output logic        ev_err,
    output logic        ev_end
);
    xfer_state_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            XS_IDLE: if (start) state_d = XS_ARB;
            XS_ARB: begin
                if (!run_ok || abort_req) state_d = XS_IDLE;
                else if (at_end)          state_d = XS_FIN;
                else if (sw_mode || req_hit) state_d = XS_RD;
            end
            XS_RD: begin
                if (!run_ok)      state_d = XS_IDLE;
                else if (bus_ack) state_d = bus_err ? XS_IDLE : XS_WR;
            end
            XS_WR: begin
                if (!run_ok)      state_d = XS_IDLE;
                else if (bus_ack) state_d = bus_err ? XS_IDLE : XS_ARB;
            end
            XS_FIN:  state_d = XS_IDLE;
            default: state_d = XS_IDLE;
        endcase
        if (clr) state_d = XS_IDLE;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= XS_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state    = state_q;
        busy     = (state_q != XS_IDLE);
        bus_req  = (state_q == XS_RD) || (state_q == XS_WR);
        bus_wr   = (state_q == XS_WR);
        arb_wait = (state_q == XS_ARB) && !sw_mode && !req_hit;
        ev_latch = (state_q == XS_RD) && run_ok && bus_ack && !bus_err && !clr;
        ev_step  = (state_q == XS_WR) && run_ok && bus_ack && !bus_err && !clr;
        ev_err   = bus_req && run_ok && bus_ack && bus_err && !clr;
        ev_abort = (state_q == XS_ARB) && run_ok && abort_req && !clr;
        ev_done  = (state_q == XS_FIN) && !clr;
        ev_end   = busy && (state_d == XS_IDLE);
    end
endmodule

// File: rtl/dmac_chan_engine.sv
module dmac_chan_engine
    import dmac_pkg::*;
#(
    parameter int AW    = 32,
    parameter int REQ_N = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [6:0]       reg_addr,
    input  logic             reg_we,
    input  logic [31:0]      reg_wdata,
    output logic [31:0]      reg_rdata,
    output logic             m_req,
    output logic             m_we,
    output logic [AW-1:0]    m_addr,
    output logic [3:0]       m_be,
    output logic [31:0]      m_wdata,
    input  logic [31:0]      m_rdata,
    input  logic             m_ack,
    input  logic             m_err,
    input  logic [REQ_N-1:0] dev_req,
    output logic             irq
);
    localparam int ID_W = 7;

    logic            glb_en, act_q;
    logic [AW-1:0]   mem_addr_q, mem_end_q, dev_addr_q;
    logic            run_q, go_q, abort_q, m2d_q, incm_q, incd_q, lock_q, swp_q, done_q;
    logic [ID_W-1:0] id_q;
    logic [2:0]      unit_q;
    logic [3:0]      sts_q, sts_d, ien_q;
    logic [31:0]     data_q;

    xfer_state_e st;
    logic busy, bus_req, bus_wr, arb_wait;
    logic ev_latch, ev_step, ev_done, ev_abort, ev_err, ev_end;
    logic req_hit, start, run_ok, at_end, srst;
    logic wr_main, wr_act, wr_mem, wr_end, wr_dev, wr_ctl, wr_sts, wr_ien;
    logic [AW-1:0] src_a, dst_a;
    logic [2:0]    unit_bytes;
    logic [AW-1:0] step;
    logic          unused_ok;

    assign wr_main = reg_we && (reg_addr == OFS_MAIN);
    assign wr_act  = reg_we && (reg_addr == OFS_ACT);
    assign wr_mem  = reg_we && (reg_addr == OFS_MEM);
    assign wr_end  = reg_we && (reg_addr == OFS_END);
    assign wr_dev  = reg_we && (reg_addr == OFS_DEV);
    assign wr_ctl  = reg_we && (reg_addr == OFS_CTL);
    assign wr_sts  = reg_we && (reg_addr == OFS_STS);
    assign wr_ien  = reg_we && (reg_addr == OFS_IEN);
    assign srst    = wr_main && reg_wdata[1];

    assign run_ok = act_q && glb_en;
    assign start  = !busy && run_ok && !srst && (swp_q ? go_q : run_q);
    assign at_end = (mem_addr_q == mem_end_q);
    assign src_a  = m2d_q ? mem_addr_q : dev_addr_q;
    assign dst_a  = m2d_q ? dev_addr_q : mem_addr_q;
    assign step   = AW'(unit_bytes);

    dmac_req_sel #(.REQ_N(REQ_N), .ID_W(ID_W)) u_rsel (
        .dev_req (dev_req),
        .sel_id  (id_q),
        .sel_hit (req_hit)
    );

    dmac_unit_dec u_unit (
        .unit_code  (unit_q),
        .lane       (m_addr[1:0]),
        .unit_bytes (unit_bytes),
        .lane_be    (m_be_raw)
    );

    logic [3:0] m_be_raw;

    dmac_xfer_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (srst),
        .start     (start),
        .run_ok    (run_ok),
        .sw_mode   (swp_q),
        .req_hit   (req_hit),
        .abort_req (abort_q),
        .at_end    (at_end),
        .bus_ack   (m_ack),
        .bus_err   (m_err),
        .state     (st),
        .busy      (busy),
        .bus_req   (bus_req),
        .bus_wr    (bus_wr),
        .arb_wait  (arb_wait),
        .ev_latch  (ev_latch),
        .ev_step   (ev_step),
        .ev_done   (ev_done),
        .ev_abort  (ev_abort),
        .ev_err    (ev_err),
        .ev_end    (ev_end)
    );

    assign m_req   = bus_req;
    assign m_we    = bus_wr;
    assign m_addr  = bus_wr ? dst_a : src_a;
    assign m_be    = bus_req ? m_be_raw : 4'b0000;
    assign m_wdata = data_q << {dst_a[1:0], 3'b000};
    assign irq     = |(sts_q & ien_q);

    always_comb begin
        sts_d = sts_q;
        if (wr_sts) sts_d = sts_q & ~reg_wdata[3:0];
        if (ev_err)   sts_d[ST_BERR] = 1'b1;
        if (ev_done)  sts_d[ST_DONE] = 1'b1;
        if (ev_abort) sts_d[ST_TERM] = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            glb_en <= 1'b0;  act_q <= 1'b0;
            mem_addr_q <= '0; mem_end_q <= '0; dev_addr_q <= '0;
            run_q <= 1'b0; go_q <= 1'b0; abort_q <= 1'b0; m2d_q <= 1'b0;
            incm_q <= 1'b0; incd_q <= 1'b0; lock_q <= 1'b0; swp_q <= 1'b0;
            done_q <= 1'b0; id_q <= '0; unit_q <= '0;
            sts_q <= '0; ien_q <= '0; data_q <= '0;
        end else begin
            if (wr_main) glb_en <= reg_wdata[0];
            if (srst) begin
                act_q <= 1'b0;
                mem_addr_q <= '0; mem_end_q <= '0; dev_addr_q <= '0;
                run_q <= 1'b0; go_q <= 1'b0; abort_q <= 1'b0; m2d_q <= 1'b0;
                incm_q <= 1'b0; incd_q <= 1'b0; lock_q <= 1'b0; swp_q <= 1'b0;
                done_q <= 1'b0; id_q <= '0; unit_q <= '0;
                sts_q <= '0; ien_q <= '0; data_q <= '0;
            end else begin
                if (wr_act) act_q <= reg_wdata[0];
                if (wr_mem && !busy)            mem_addr_q <= AW'(reg_wdata);
                else if (ev_step && incm_q)     mem_addr_q <= mem_addr_q + step;
                if (wr_dev && !busy)            dev_addr_q <= AW'(reg_wdata);
                else if (ev_step && incd_q)     dev_addr_q <= dev_addr_q + step;
                if (wr_end && !busy)            mem_end_q  <= AW'(reg_wdata);
                if (wr_ctl) begin
                    if (!busy) begin
                        run_q   <= reg_wdata[CB_RUN];
                        m2d_q   <= reg_wdata[CB_M2D];
                        id_q    <= reg_wdata[CB_ID_LO +: ID_W];
                        incm_q  <= reg_wdata[CB_INCM];
                        incd_q  <= reg_wdata[CB_INCD];
                        lock_q  <= reg_wdata[CB_LOCK];
                        swp_q   <= reg_wdata[CB_SWP];
                        unit_q  <= reg_wdata[CB_UN_LO +: 3];
                        go_q    <= reg_wdata[CB_GO];
                        abort_q <= reg_wdata[CB_ABT];
                    end else begin
                        abort_q <= abort_q | reg_wdata[CB_ABT];
                    end
                end
                if (ev_end) begin
                    run_q <= 1'b0; go_q <= 1'b0; abort_q <= 1'b0;
                end
                if (start)   done_q <= 1'b0;
                if (ev_done) done_q <= 1'b1;
                sts_q <= sts_d;
                if (wr_ien) ien_q <= reg_wdata[3:0];
                if (ev_latch) data_q <= m_rdata >> {src_a[1:0], 3'b000};
            end
        end
    end

    always_comb begin
        reg_rdata = '0;
        unique case (reg_addr)
            OFS_MAIN: reg_rdata[0] = glb_en;
            OFS_ACT:  reg_rdata[0] = act_q;
            OFS_MEM:  reg_rdata = 32'(mem_addr_q);
            OFS_END:  reg_rdata = 32'(mem_end_q);
            OFS_DEV:  reg_rdata = 32'(dev_addr_q);
            OFS_CTL: begin
                reg_rdata[CB_RUN]            = run_q;
                reg_rdata[CB_REQ]            = req_hit;
                reg_rdata[CB_DONE]           = done_q;
                reg_rdata[CB_BUSY]           = busy;
                reg_rdata[CB_M2D]            = m2d_q;
                reg_rdata[CB_ID_LO +: ID_W]  = id_q;
                reg_rdata[CB_INCM]           = incm_q;
                reg_rdata[CB_INCD]           = incd_q;
                reg_rdata[CB_LOCK]           = lock_q;
                reg_rdata[CB_SWP]            = swp_q;
                reg_rdata[CB_UN_LO +: 3]     = unit_q;
                reg_rdata[CB_GO]             = go_q;
                reg_rdata[CB_ABT]            = abort_q;
            end
            OFS_STS:  reg_rdata[3:0] = sts_q;
            OFS_IEN:  reg_rdata[3:0] = ien_q;
            OFS_FSM: begin
                reg_rdata[15:8] = st;
                reg_rdata[0]    = arb_wait;
            end
            default:  reg_rdata = '0;
        endcase
    end

    assign unused_ok = ^{reg_wdata[31:26], reg_wdata[23], reg_wdata[7:4]};
endmodule

// File: rtl/dmac_chan_chk.sv
module dmac_chan_chk #(
    parameter int AW = 32
) (
    input logic          clk,
    input logic          rst_n,
    input logic          m_req,
    input logic          m_we,
    input logic          m_ack,
    input logic          m_err,
    input logic [AW-1:0] m_addr,
    input logic [3:0]    m_be,
    input logic          busy,
    input logic [3:0]    sts,
    input logic [AW-1:0] mem_addr,
    input logic [AW-1:0] mem_end
);
    // R14
    bus_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !m_req);

    // R14
    addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (m_req && !m_ack) |=> (!m_req || ($stable(m_addr) && $stable(m_we))));

    // R4
    be_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
        m_req |-> ($countones(m_be) == 1 || $countones(m_be) == 2 || $countones(m_be) == 4));

    // R6
    done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sts[2]) |-> !busy);

    // R6
    end_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        m_req |-> (mem_addr != mem_end));

    // R9
    err_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (m_req && m_ack && m_err) |=> !m_req);
endmodule

bind dmac_chan_engine dmac_chan_chk #(.AW(AW)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .m_req    (m_req),
    .m_we     (m_we),
    .m_ack    (m_ack),
    .m_err    (m_err),
    .m_addr   (m_addr),
    .m_be     (m_be),
    .busy     (busy),
    .sts      (sts_q),
    .mem_addr (mem_addr_q),
    .mem_end  (mem_end_q)
);

// File: tb/sim_dmac_chan_engine.sv
module sim_dmac_chan_engine;
    localparam int CLK_T = 10;
    localparam int AW    = 32;
    localparam int REQ_N = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [6:0]  reg_addr = '0;
    logic        reg_we = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic m_req, m_we, m_ack, m_err;
    logic [AW-1:0] m_addr;
    logic [3:0] m_be;
    logic [31:0] m_wdata, m_rdata;
    logic [REQ_N-1:0] dev_req = '0;
    logic irq;

    logic [7:0] mem [0:255];
    logic [7:0] exp_m [0:255];
    logic       err_en = 1'b0;
    logic [7:0] err_at = '0;
    logic       fill_req = 1'b0;
    logic [7:0] fill_seed = '0;
    logic [3:0] last_be = '0;
    int req_cnt = 0;
    int n_chk = 0, n_bad = 0, cyc = 0;

    always #(CLK_T/2) clk = ~clk;

    dmac_chan_engine #(.AW(AW), .REQ_N(REQ_N)) u0 (
        .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_we(reg_we),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .m_req(m_req), .m_we(m_we),
        .m_addr(m_addr), .m_be(m_be), .m_wdata(m_wdata), .m_rdata(m_rdata),
        .m_ack(m_ack), .m_err(m_err), .dev_req(dev_req), .irq(irq)
    );

    function automatic logic [7:0] pat(input int i, input logic [7:0] s);
        return 8'((i * 7) + int'(s)) ^ 8'h5A;
    endfunction

    assign m_ack = m_req;
    assign m_err = m_req && err_en && (m_addr[7:0] == err_at);
    always_comb m_rdata = {mem[{m_addr[7:2], 2'd3}], mem[{m_addr[7:2], 2'd2}],
                           mem[{m_addr[7:2], 2'd1}], mem[{m_addr[7:2], 2'd0}]};

    always @(posedge clk) begin
        if (fill_req) begin
            for (int i = 0; i < 256; i++) mem[i] <= pat(i, fill_seed);
        end else if (m_req && m_we && m_ack && !m_err) begin
            for (int j = 0; j < 4; j++)
                if (m_be[j]) mem[{m_addr[7:2], 2'(j)}] <= m_wdata[8*j +: 8];
        end
        if (m_req) req_cnt <= req_cnt + 1;
        if (m_req && m_we && m_ack) last_be <= m_be;
    end

    task automatic summary();
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    endtask

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc == 150000) begin
            n_chk = n_chk + 1;
            n_bad = n_bad + 1;
            $display("FAIL watchdog act=%0d exp=<150000", cyc);
            summary();
            $finish;
        end
    end

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] expv);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s act=%h exp=%h", req, act, expv);
        end
    endtask

    task automatic wr(input logic [6:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_we = 1'b1;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic [6:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic idle_cycles(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic wait_idle();
        logic [31:0] v;
        v = '0;
        for (int i = 0; i < 3000; i++) begin
            rd(7'h50, v);
            if (!v[5]) return;
        end
        chk(1'b0, "R6 busy never cleared", v, 32'h0);
    endtask

    task automatic fill(input logic [7:0] s);
        @(negedge clk);
        fill_seed = s; fill_req = 1'b1;
        @(negedge clk);
        fill_req = 1'b0;
        for (int i = 0; i < 256; i++) exp_m[i] = pat(i, s);
    endtask

    function automatic int mism();
        int c = 0;
        for (int i = 0; i < 256; i++) if (mem[i] !== exp_m[i]) c++;
        return c;
    endfunction

    function automatic logic [31:0] mk_ctl(input bit run, input bit go, input bit m2d, input int id,
                                           input bit im, input bit idv, input bit swp, input int u);
        logic [31:0] v;
        v = '0;
        v[0] = run; v[8] = m2d; v[15:9] = 7'(id); v[16] = im; v[17] = idv;
        v[19] = swp; v[22:20] = 3'(u); v[24] = go;
        return v;
    endfunction

    task automatic model_copy(input int mb, input int db, input int u, input int n,
                              input bit m2d, input bit idv);
        for (int k = 0; k < n; k++) begin
            int ma = mb + k * u;
            int da = db + (idv ? k * u : 0);
            for (int j = 0; j < u; j++) begin
                if (m2d) exp_m[(da + j) & 255] = exp_m[(ma + j) & 255];
                else     exp_m[(ma + j) & 255] = exp_m[(da + j) & 255];
            end
        end
    endtask

    initial begin
        logic [31:0] v, v2;
        int ma;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        for (int a = 0; a < 8; a++) begin
            rd(7'(7'h40 + 4 * a), v);
            chk(v == 32'h0, "R1 reset channel reg", v, 32'h0);
        end
        rd(7'h00, v);
        chk(v == 32'h0 && !irq && !m_req, "R1 reset main/irq/req", v, 32'h0);

        wr(7'h00, 32'h1);
        wr(7'h40, 32'h1);
        rd(7'h40, v);
        chk(v == 32'h1, "R2 activate readback", v, 32'h1);

        // R4 R5 R6 sweep over unit, direction, device increment and length
        for (int ui = 0; ui < 3; ui++) begin
            for (int dir = 0; dir < 2; dir++) begin
                for (int idv = 0; idv < 2; idv++) begin
                    for (int n = 1; n <= 3; n++) begin
                        int u  = (ui == 0) ? 1 : (ui == 1) ? 2 : 4;
                        int mb = (u == 1) ? 8'h21 : (u == 2) ? 8'h22 : 8'h20;
                        int db = (u == 1) ? 8'h83 : (u == 2) ? 8'h80 : 8'h84;
                        int dl;
                        logic [3:0] ebe;
                        fill(8'(ui * 16 + dir * 8 + idv * 4 + n));
                        model_copy(mb, db, u, n, dir[0], idv[0]);
                        wr(7'h44, 32'(mb));
                        wr(7'h48, 32'(mb + n * u));
                        wr(7'h4C, 32'(db));
                        wr(7'h50, mk_ctl(1'b0, 1'b1, dir[0], 0, 1'b1, idv[0], 1'b1, u));
                        wait_idle();
                        chk(mism() == 0, "R4 copied bytes", 32'(mism()), 32'h0);
                        rd(7'h44, v);
                        chk(v == 32'(mb + n * u), "R5 memory address end", v, 32'(mb + n * u));
                        rd(7'h4C, v);
                        chk(v == 32'(db + (idv != 0 ? n * u : 0)), "R5 device address step", v,
                            32'(db + (idv != 0 ? n * u : 0)));
                        dl = dir != 0 ? db + (idv != 0 ? (n - 1) * u : 0) : mb + (n - 1) * u;
                        ebe = 4'(((1 << u) - 1) << (dl & 3));
                        chk(last_be == ebe, "R4 byte enables", 32'(last_be), 32'(ebe));
                        rd(7'h50, v);
                        rd(7'h54, v2);
                        chk(v[2] && !v[5] && v2[2], "R6 done flags", {v[15:0], v2[15:0]}, 32'h0004_0004);
                        wr(7'h54, 32'hF);
                    end
                end
            end
        end

        // R5 invalid unit code acts as one byte; R2 control readback
        fill(8'h33);
        model_copy(8'h31, 8'hA1, 1, 2, 1'b1, 1'b1);
        wr(7'h44, 32'h31); wr(7'h48, 32'h33); wr(7'h4C, 32'hA1);
        wr(7'h50, mk_ctl(1'b0, 1'b1, 1'b1, 9, 1'b1, 1'b1, 1'b1, 3) | 32'h0004_0000);
        wait_idle();
        chk(mism() == 0, "R5 code 3 one-byte units", 32'(mism()), 32'h0);
        rd(7'h50, v);
        v2 = (mk_ctl(1'b0, 1'b0, 1'b1, 9, 1'b1, 1'b1, 1'b1, 3) | 32'h0004_0004);
        chk((v & 32'h03FF_FF05) == v2, "R2 control readback", v, v2);
        wr(7'h54, 32'hF);

        // R6 zero length: done with no bus traffic
        wr(7'h44, 32'h10); wr(7'h48, 32'h10);
        v2 = 32'(req_cnt);
        wr(7'h50, mk_ctl(1'b0, 1'b1, 1'b1, 0, 1'b1, 1'b1, 1'b1, 1));
        wait_idle();
        rd(7'h54, v);
        chk(v[2] && req_cnt == int'(v2), "R6 zero length", {v[15:0], 16'(req_cnt - int'(v2))}, 32'h0004_0000);

        // R10 interrupt gating and write-one-to-clear
        chk(!irq, "R10 irq masked", 32'(irq), 32'h0);
        wr(7'h58, 32'h4);
        chk(irq, "R10 irq enabled", 32'(irq), 32'h1);
        wr(7'h54, 32'hB);
        rd(7'h54, v);
        chk(v == 32'h4 && irq, "R10 zero bits keep", v, 32'h4);
        wr(7'h54, 32'h4);
        rd(7'h54, v);
        chk(v == 32'h0 && !irq, "R10 cleared", v, 32'h0);
        wr(7'h58, 32'h0);

        // R7 R11 R13 hardware pacing
        fill(8'h71);
        model_copy(8'h10, 8'h90, 1, 4, 1'b1, 1'b1);
        wr(7'h44, 32'h10); wr(7'h48, 32'h14); wr(7'h4C, 32'h90);
        wr(7'h50, mk_ctl(1'b1, 1'b0, 1'b1, 5, 1'b1, 1'b1, 1'b0, 1));
        idle_cycles(10);
        rd(7'h5C, v);
        chk(v == 32'h0101, "R11 waiting state", v, 32'h0101);
        rd(7'h44, v);
        chk(v == 32'h10, "R7 no progress without request", v, 32'h10);
        wr(7'h44, 32'h55); wr(7'h48, 32'h66);
        rd(7'h44, v); rd(7'h48, v2);
        chk(v == 32'h10 && v2 == 32'h14, "R13 address writes ignored", {v[15:0], v2[15:0]}, 32'h0010_0014);
        dev_req[3] = 1'b1;
        idle_cycles(10);
        rd(7'h50, v);
        rd(7'h44, v2);
        chk(v2 == 32'h10 && !v[1] && v[5], "R7 other line ignored", {v[15:0], v2[15:0]}, 32'h0020_0010);
        dev_req[5] = 1'b1;
        rd(7'h50, v);
        chk(v[1], "R7 request bit shows line", v, 32'h2);
        wait_idle();
        chk(mism() == 0, "R7 paced copy", 32'(mism()), 32'h0);
        rd(7'h5C, v);
        chk(v == 32'h0, "R11 idle code", v, 32'h0);
        dev_req = '0;
        wr(7'h54, 32'hF);

        // R7 R8 out-of-range ID never matches, then abort
        dev_req = '1;
        wr(7'h44, 32'h10); wr(7'h48, 32'h14);
        wr(7'h50, mk_ctl(1'b1, 1'b0, 1'b1, 100, 1'b1, 1'b1, 1'b0, 1));
        idle_cycles(10);
        rd(7'h44, v);
        chk(v == 32'h10, "R7 out of range ID", v, 32'h10);
        wr(7'h50, 32'h0200_0000);
        wait_idle();
        rd(7'h54, v);
        chk(v == 32'h8, "R8 abort status while waiting", v, 32'h8);
        dev_req = '0;
        wr(7'h54, 32'hF);

        // R8 R13 abort in the middle of a software transfer
        fill(8'h18);
        wr(7'h44, 32'h00); wr(7'h48, 32'h40); wr(7'h4C, 32'h80);
        wr(7'h50, mk_ctl(1'b0, 1'b1, 1'b1, 0, 1'b1, 1'b1, 1'b1, 1));
        wr(7'h50, 32'h0240_0000);
        wait_idle();
        rd(7'h44, v);
        ma = int'(v);
        chk(ma > 0 && ma < 64, "R8 stopped inside block", v, 32'h1);
        model_copy(0, 8'h80, 1, ma, 1'b1, 1'b1);
        chk(mism() == 0, "R8 whole units only", 32'(mism()), 32'h0);
        rd(7'h54, v); rd(7'h50, v2);
        chk(v == 32'h8 && !v2[2] && !v2[5] && !v2[25], "R8 status and flags", {v[15:0], v2[15:0]}, 32'h0008_0000);
        chk(v2[22:20] == 3'd1, "R13 unit kept during busy write", 32'(v2[22:20]), 32'h1);
        wr(7'h54, 32'hF);

        // R9 bus error on a write
        fill(8'h44);
        err_en = 1'b1; err_at = 8'hC8;
        model_copy(8'h40, 8'hC0, 4, 2, 1'b1, 1'b1);
        wr(7'h44, 32'h40); wr(7'h48, 32'h50); wr(7'h4C, 32'hC0);
        wr(7'h50, mk_ctl(1'b0, 1'b1, 1'b1, 0, 1'b1, 1'b1, 1'b1, 4));
        wait_idle();
        err_en = 1'b0;
        rd(7'h44, v); rd(7'h54, v2);
        chk(v == 32'h48 && v2 == 32'h1, "R9 error stop", {v[15:0], v2[15:0]}, 32'h0048_0001);
        chk(mism() == 0, "R9 memory after error", 32'(mism()), 32'h0);
        wr(7'h54, 32'hF);

        // R12 activate clear mid-transfer
        wr(7'h44, 32'h00); wr(7'h48, 32'h40); wr(7'h4C, 32'h80);
        wr(7'h50, mk_ctl(1'b0, 1'b1, 1'b1, 0, 1'b1, 1'b1, 1'b1, 1));
        wr(7'h40, 32'h0);
        rd(7'h50, v); rd(7'h5C, v2);
        chk(!v[5] && v2 == 32'h0, "R12 forced idle", {v[15:0], v2[15:0]}, 32'h0);
        wr(7'h40, 32'h1);

        // R3 global enable gate and pending go
        wr(7'h00, 32'h0);
        wr(7'h44, 32'h10); wr(7'h48, 32'h12);
        wr(7'h50, mk_ctl(1'b0, 1'b1, 1'b1, 0, 1'b1, 1'b1, 1'b1, 1));
        idle_cycles(8);
        rd(7'h50, v);
        chk(!v[5] && v[24], "R3 held while disabled", v, 32'h0100_0000);
        wr(7'h00, 32'h1);
        wait_idle();
        rd(7'h44, v);
        chk(v == 32'h12, "R3 pending go runs", v, 32'h12);

        // R1 soft reset
        wr(7'h58, 32'hF);
        wr(7'h00, 32'h3);
        rd(7'h00, v);
        chk(v == 32'h1, "R1 main after soft reset", v, 32'h1);
        for (int a = 0; a < 8; a++) begin
            rd(7'(7'h40 + 4 * a), v);
            chk(v == 32'h0, "R1 soft reset clears", v, 32'h0);
        end

        summary();
        $finish;
    end
endmodule